// File: doc/BRIEF.md
# Bus Listener Address Control

This block decides when an instrument on an IEEE-488 style parallel bus has been addressed as a listener. It watches the bus control lines and the data lines, and it drives a clock for a downstream word store. While the attention line is asserted (command mode), each data-accepted strobe from the acceptor handshake carries a command byte. A listen-group byte that the external address comparator matches makes the device a listener. The unlisten byte, or an interface clear, removes it.

While the device is listening and attention is released (data mode), each accepted byte becomes one clock pulse of fixed length in system clock cycles. The downstream sequencer latches the byte on that pulse. Whenever listening is cancelled, the block also pulses a clear toward that sequencer. All inputs arrive already converted to positive logic. Attention, interface clear and the strobe each pass through two synchronizer flip-flops before use. The data lines and the address match are taken as stable for the whole strobe.

Top module: `bus_listen_ctrl`

## Requirements
- R1: After a synchronous reset, listen_o, lamp_o, seq_clr_o and data_clk_o are all low.
- R2: With atn_i high, a rising acds_i sets the listen state when addr_match_i is high, dio_i[6:5] equals 2'b01 and dio_i[6:0] is not 7'h3F. Any other byte or match value leaves the state unchanged. dio_i[7] is ignored.
- R3: With atn_i high, a rising acds_i with dio_i[6:0] equal to 7'h3F clears the listen state whatever addr_match_i is, and seq_clr_o goes high for exactly one cycle.
- R4: With atn_i low, acds_i strobes never change the listen state, including strobes carrying listen or unlisten codes.
- R5: While the synchronized ifc_i is high, the listen state is cleared and seq_clr_o is high for the same number of cycles. Any running data clock pulse is cut short.
- R6: With the listen state set and atn_i low, each accepted rising acds_i produces one high pulse on data_clk_o lasting exactly PULSE_W clock cycles.
- R7: No data_clk_o pulse starts while the listen state is clear or while atn_i is high.
- R8: A rising acds_i that arrives while data_clk_o is high is ignored. The pulse is neither extended nor repeated.
- R9: lamp_o always equals listen_o.
- R10: A listen-state change appears on listen_o on the third rising clock edge after the causing acds_i edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| atn_i | input | 1 | Attention, high means command mode |
| ifc_i | input | 1 | Interface clear, high means asserted |
| acds_i | input | 1 | Data-accepted strobe from the acceptor handshake |
| dio_i | input | 8 | Bus data lines, bit 0 is DIO1 |
| addr_match_i | input | 1 | High when the external comparator matches the device address |
| listen_o | output | 1 | Listen state |
| lamp_o | output | 1 | Drive for the listening indicator |
| seq_clr_o | output | 1 | Clear toward the downstream word sequencer |
| data_clk_o | output | 1 | One pulse per byte accepted in data mode while listening |

## Verification
The listen flag is the only long-lived state, and it is visible directly on listen_o and lamp_o. A wrong set or clear therefore appears at the ports three cycles after the strobe that caused it. A stuck pulse counter shows as a data_clk_o pulse whose high-cycle count differs from PULSE_W. A wrong busy check shows as a second rising edge of data_clk_o, or as a stretched pulse, when strobes are spaced closer than PULSE_W. The bench sweeps every command byte, with the match input both low and high, and from both the idle and the listening state. Every one of these faults therefore shows up within a single strobe.

// File: rtl/lstn_pkg.sv
package lstn_pkg;

    typedef struct packed {
        logic atn;
        logic ifc;
        logic acds;
    } busctl_t;

    localparam logic [6:0] UNL_CODE = 7'h3F;
    localparam logic [1:0] LGRP_TAG = 2'b01;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_LISTEN,
        CMD_UNLISTEN
    } cmd_kind_t;

    function automatic cmd_kind_t decode_cmd(logic [7:0] d, logic match);
        if (d[6:0] == UNL_CODE)
            return CMD_UNLISTEN;
        if (d[6:5] == LGRP_TAG && match)
            return CMD_LISTEN;
        return CMD_NONE;
    endfunction

endpackage

// File: rtl/lstn_sync.sv
module lstn_sync
    import lstn_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk_i,
    input  logic    rst_i,
    input  busctl_t raw_i,
    output busctl_t sync_o,
    output logic    acds_rise_o
);
    busctl_t pipe [STAGES];
    logic    acds_last;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    pipe[g] <= '0;
                end else if (g == 0) begin
                    pipe[g] <= raw_i;
                end else begin
                    pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i) acds_last <= 1'b0;
        else       acds_last <= pipe[STAGES-1].acds;
    end

    assign sync_o      = pipe[STAGES-1];
    assign acds_rise_o = pipe[STAGES-1].acds & ~acds_last;

endmodule

// File: rtl/lstn_state.sv
module lstn_state
    import lstn_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  busctl_t    bus_i,
    input  logic       acds_rise_i,
    input  logic [7:0] dio_i,
    input  logic       match_i,
    output logic       listen_o,
    output logic       seq_clr_o,
    output logic       clr_evt_o
);
    cmd_kind_t cmd;
    logic      cmd_strobe;
    logic      listen_q;
    logic      clr_q;

    assign cmd        = decode_cmd(dio_i, match_i);
    assign cmd_strobe = acds_rise_i & bus_i.atn;
    assign clr_evt_o  = bus_i.ifc | (cmd_strobe && cmd == CMD_UNLISTEN);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            listen_q <= 1'b0;
            clr_q    <= 1'b0;
        end else begin
            clr_q <= clr_evt_o;
            if (clr_evt_o)
                listen_q <= 1'b0;
            else if (cmd_strobe && cmd == CMD_LISTEN)
                listen_q <= 1'b1;
        end
    end

    assign listen_o  = listen_q;
    assign seq_clr_o = clr_q;

    // R2
    listen_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(listen_q) |-> $past(acds_rise_i && bus_i.atn && match_i));

    // R4
    data_mode_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!bus_i.atn && !bus_i.ifc) |=> $stable(listen_q));

    // R5
    ifc_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        bus_i.ifc |=> (!listen_q && clr_q));

    // R3
    clr_implies_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_q |-> !listen_q);

endmodule

// File: rtl/lstn_pulse.sv
module lstn_pulse #(
    parameter int PULSE_W = 800
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic trig_i,
    input  logic enable_i,
    input  logic abort_i,
    input  logic listen_i,
    output logic pulse_o
);
    localparam int CW = $clog2(PULSE_W + 1);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_W);

    logic [CW-1:0] cnt;
    logic          busy;

    assign busy = (cnt != '0);

    always_ff @(posedge clk_i) begin
        if (rst_i || abort_i)
            cnt <= '0;
        else if (busy)
            cnt <= cnt - 1'b1;
        else if (trig_i && enable_i)
            cnt <= LOAD;
    end

    assign pulse_o = busy;

    // R7
    pulse_needs_listen_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_o |-> listen_i);

    // R6
    pulse_start_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(pulse_o) |-> $past(trig_i && enable_i));

    // R8
    no_reload_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy && !abort_i) |=> (cnt == $past(cnt) - 1'b1));

    // R6
    cnt_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt <= LOAD);

endmodule

// File: rtl/bus_listen_ctrl.sv
module bus_listen_ctrl
    import lstn_pkg::*;
#(
    parameter int PULSE_W     = 800,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       atn_i,
    input  logic       ifc_i,
    input  logic       acds_i,
    input  logic [7:0] dio_i,
    input  logic       addr_match_i,
    output logic       listen_o,
    output logic       lamp_o,
    output logic       seq_clr_o,
    output logic       data_clk_o
);
    busctl_t raw, bus;
    logic    acds_rise;
    logic    listen;
    logic    clr_evt;

    assign raw = '{atn: atn_i, ifc: ifc_i, acds: acds_i};

    lstn_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .raw_i       (raw),
        .sync_o      (bus),
        .acds_rise_o (acds_rise)
    );

    lstn_state u_state (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .bus_i       (bus),
        .acds_rise_i (acds_rise),
        .dio_i       (dio_i),
        .match_i     (addr_match_i),
        .listen_o    (listen),
        .seq_clr_o   (seq_clr_o),
        .clr_evt_o   (clr_evt)
    );

    lstn_pulse #(.PULSE_W(PULSE_W)) u_pulse (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .trig_i   (acds_rise),
        .enable_i (listen & ~bus.atn),
        .abort_i  (clr_evt),
        .listen_i (listen),
        .pulse_o  (data_clk_o)
    );

    assign listen_o = listen;
    assign lamp_o   = listen;

    // R9
    lamp_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        lamp_o == listen_o);

endmodule

// File: tb/bus_listen_ctrl_test.sv
module bus_listen_ctrl_test;
    localparam int PW = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       atn = 1'b0, ifc = 1'b0, acds = 1'b0, match = 1'b0;
    logic [7:0] dio = '0;
    logic       listen_o, lamp_o, seq_clr_o, data_clk_o;

    int n_chk = 0, n_fail = 0;
    int pulse_hi = 0, pulse_rise = 0, clr_hi = 0;
    logic pulse_prev = 1'b0;

    bus_listen_ctrl #(.PULSE_W(PW)) uut (
        .clk_i(clk), .rst_i(rst), .atn_i(atn), .ifc_i(ifc), .acds_i(acds),
        .dio_i(dio), .addr_match_i(match), .listen_o(listen_o),
        .lamp_o(lamp_o), .seq_clr_o(seq_clr_o), .data_clk_o(data_clk_o)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        if (data_clk_o) pulse_hi++;
        if (data_clk_o && !pulse_prev) pulse_rise++;
        pulse_prev = data_clk_o;
        if (seq_clr_o) clr_hi++;
    end

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic put(logic cmd, logic [7:0] d, logic m);
        atn = cmd; dio = d; match = m;
        cyc(4);
    endtask

    task automatic strobe();
        acds = 1'b1; cyc(6);
        acds = 1'b0; cyc(8);
    endtask

    task automatic go_listen();
        put(1'b1, 8'h25, 1'b1);
        strobe();
    endtask

    function automatic int exp_set(logic [7:0] d, logic m);
        return (m && d[6:5] == 2'b01 && d[6:0] != 7'h3F) ? 1 : 0;
    endfunction

    initial begin
        cyc(150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_up();
    end

    initial begin
        int b_hi, b_rise, b_clr;
        cyc(4);
        rst = 1'b0;
        cyc(1);
        // R1 reset state
        check("R1 listen", listen_o, 0);
        check("R1 lamp", lamp_o, 0);
        check("R1 seq_clr", seq_clr_o, 0);
        check("R1 data_clk", data_clk_o, 0);

        // R10 exact latency
        put(1'b1, 8'h2A, 1'b1);
        acds = 1'b1;
        cyc(2);
        check("R10 early", listen_o, 0);
        cyc(2);
        check("R10 on time", listen_o, 1);
        cyc(2); acds = 1'b0; cyc(8);
        put(1'b1, 8'h3F, 1'b0); strobe();

        // R2 / R3 sweep from idle
        for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 256; c++) begin
                put(1'b1, 8'(c), 1'(m));
                strobe();
                check("R2 set sweep", listen_o, exp_set(8'(c), 1'(m)));
                check("R9 lamp", lamp_o, listen_o);
                if (listen_o) begin
                    put(1'b1, 8'h3F, 1'b0);
                    b_clr = clr_hi;
                    strobe();
                    check("R3 unlisten", listen_o, 0);
                    check("R3 clr one cycle", clr_hi - b_clr, 1);
                end
            end
        end

        // R3 / R2 sweep from listening, match low
        go_listen();
        for (int c = 0; c < 256; c++) begin
            put(1'b1, 8'(c), 1'b0);
            strobe();
            check("R3 sweep listening", listen_o, (c[6:0] == 7'h3F) ? 0 : 1);
            if (!listen_o) go_listen();
        end
        put(1'b1, 8'h3F, 1'b1); strobe();
        check("R3 unlisten with match", listen_o, 0);

        // R4 data mode ignores commands
        put(1'b0, 8'h25, 1'b1); strobe();
        check("R4 no set in data mode", listen_o, 0);
        go_listen();
        put(1'b0, 8'h3F, 1'b0); strobe();
        check("R4 no clear in data mode", listen_o, 1);

        // R6 pulse width for several bytes
        for (int k = 0; k < 4; k++) begin
            put(1'b0, 8'(k * 37 + 1), 1'(k % 2));
            b_hi = pulse_hi; b_rise = pulse_rise;
            strobe();
            check("R6 width", pulse_hi - b_hi, PW);
            check("R6 one pulse", pulse_rise - b_rise, 1);
        end

        // R8 second edge during pulse
        b_hi = pulse_hi; b_rise = pulse_rise;
        acds = 1'b1; cyc(2); acds = 1'b0; cyc(2);
        acds = 1'b1; cyc(2); acds = 1'b0; cyc(14);
        check("R8 width", pulse_hi - b_hi, PW);
        check("R8 one pulse", pulse_rise - b_rise, 1);

        // R7 command mode while listening
        put(1'b1, 8'h10, 1'b0);
        b_rise = pulse_rise;
        strobe();
        check("R7 cmd mode no pulse", pulse_rise - b_rise, 0);

        // R5 IFC during pulse
        put(1'b0, 8'h55, 1'b0);
        b_hi = pulse_hi; b_clr = clr_hi;
        acds = 1'b1; cyc(5);
        ifc = 1'b1; cyc(4); ifc = 1'b0;
        acds = 1'b0; cyc(8);
        check("R5 listen cleared", listen_o, 0);
        check("R5 clr length", clr_hi - b_clr, 4);
        check("R5 pulse cut", (pulse_hi - b_hi) < PW ? 1 : 0, 1);
        check("R9 lamp after ifc", lamp_o, 0);

        // R7 not listening, data mode
        b_rise = pulse_rise;
        strobe();
        check("R7 idle no pulse", pulse_rise - b_rise, 0);

        finish_up();
    end
endmodule